// File: doc/BRIEF.md
# Host I/O Port Decoder with Lockable Configuration

This block sits between a host's 16-bit I/O bus and three on-chip device channels: a keyboard/mouse controller, a power-management mailbox and a real-time clock. It compares every host I/O address against each channel's base. When a read or write strobe is active, it raises one of two selects for the matching channel, which tells the channel's even (data or index) port apart from its odd (command/status or data) port. The selects are combinational, so a device sees its select in the same cycle as the address and strobe.

Each channel has an enable bit and a relocatable base. The host programs them through a small write-only configuration port. Writing the lock bit freezes the whole configuration until the next reset. Four device interrupt requests are gated by their channel's enable, registered, and driven out on the legacy lines irq1 (keyboard), irq12 (mouse), irq11 (power management) and irq8 (clock).

Top module: `hostio_decode`

## Requirements
- R1: After reset the keyboard base is 0x0060, the power-management base is 0x0062 and the clock base is 0x0070. All three channels are enabled, the configuration is unlocked, and all four IRQ outputs are low.
- R2: The keyboard channel matches when all address bits other than bit 2 equal its base. The address is compared over all 16 bits. kbd_dat_sel is raised when address bit 2 is 0 and kbd_cmd_sel when it is 1.
- R3: The power-management channel uses the same rule as the keyboard channel. pm_dat_sel is raised when address bit 2 is 0 and pm_cmd_sel when it is 1.
- R4: The clock channel matches when all address bits other than bit 0 equal its base. rtc_idx_sel is raised when bit 0 is 0 and rtc_dat_sel when it is 1.
- R5: A select is raised only while io_rd or io_wr is high, and at most one select is high at any time.
- R6: When the address ranges of several channels overlap, the keyboard channel wins over the power-management channel, and the power-management channel wins over the clock channel.
- R7: A configuration write with cfg_we high takes effect at the next clock edge. Index 0 is the control register. Indices 1 and 2 are the keyboard base low and high bytes, 3 and 4 the power-management base, and 5 and 6 the clock base. Index 7 has no effect.
- R8: Control bits 0, 1 and 2 enable the keyboard, power-management and clock channels. A disabled channel raises no select, and the address falls through to the next enabled channel that matches.
- R9: One cycle after a request input is sampled, the matching output is high if the request was high and the channel was enabled, and low otherwise. kbd_req drives irq1, mouse_req drives irq12 (keyboard enable), pm_req drives irq11 and rtc_req drives irq8.
- R10: Writing control bit 7 as 1 sets the lock. From then on every configuration write is ignored, including writes that try to clear the lock, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host I/O read strobe |
| io_wr | input | 1 | Host I/O write strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| kbd_req | input | 1 | Keyboard interrupt request |
| mouse_req | input | 1 | Mouse interrupt request |
| pm_req | input | 1 | Power-management interrupt request |
| rtc_req | input | 1 | Clock interrupt request |
| kbd_dat_sel | output | 1 | Keyboard data port select |
| kbd_cmd_sel | output | 1 | Keyboard command/status port select |
| pm_dat_sel | output | 1 | Power-management data port select |
| pm_cmd_sel | output | 1 | Power-management command/status port select |
| rtc_idx_sel | output | 1 | Clock index port select |
| rtc_dat_sel | output | 1 | Clock data port select |
| irq1 | output | 1 | Keyboard interrupt line |
| irq12 | output | 1 | Mouse interrupt line |
| irq11 | output | 1 | Power-management interrupt line |
| irq8 | output | 1 | Clock interrupt line |

## Verification
A corrupted base or enable bit shows up as a select at the wrong address, or a missing one, in the same cycle an affected address is driven. A corrupted enable bit also shows up on the matching IRQ line one cycle after a request. A lost lock stays invisible until the next configuration write. Its effect then appears in the decode one cycle after that write. The bench therefore runs random probe addresses around the current bases after each configuration change, and it makes write attempts after the lock is set and then probes the old and new addresses.

// File: rtl/hio_pkg.sv
`timescale 1ns/1ps
package hio_pkg;
    localparam int AW      = 16;   // host address width
    localparam int DW      = 8;    // configuration data width
    localparam int NCH     = 3;    // number of device channels
    localparam int IW      = 3;    // configuration index width
    localparam int HW      = AW - DW;
    localparam int LOCK_BIT = 7;

    localparam int CH_KBD = 0;
    localparam int CH_PM  = 1;
    localparam int CH_RTC = 2;

    localparam logic [IW-1:0] IDX_CTRL = '0;

    typedef struct packed {
        logic                         lock;
        logic [NCH-1:0]               en;
        logic [NCH-1:0][AW-1:0]       base;
    } cfg_state_t;

    typedef struct packed {
        logic kbd;
        logic mouse;
        logic pm;
        logic rtc;
    } irq_vec_t;

    function automatic logic [AW-1:0] default_base(input int ch);
        case (ch)
            CH_KBD:  return AW'(16'h0060);
            CH_PM:   return AW'(16'h0062);
            default: return AW'(16'h0070);
        endcase
    endfunction

    function automatic cfg_state_t cfg_reset_value();
        cfg_state_t s;
        s.lock = 1'b0;
        s.en   = '1;
        for (int ch = 0; ch < NCH; ch++) s.base[ch] = default_base(ch);
        return s;
    endfunction

    function automatic logic [IW-1:0] base_lo_idx(input int ch);
        return IW'(1 + 2 * ch);
    endfunction

    function automatic logic [IW-1:0] base_hi_idx(input int ch);
        return IW'(2 + 2 * ch);
    endfunction
endpackage

// File: rtl/hio_cfg_regs.sv
`timescale 1ns/1ps
module hio_cfg_regs
    import hio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output cfg_state_t    cfg
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && !st_q.lock) begin
            if (idx == IDX_CTRL) begin
                st_d.en   = wdata[NCH-1:0];
                st_d.lock = wdata[LOCK_BIT];
            end
            for (int ch = 0; ch < NCH; ch++) begin
                if (idx == base_lo_idx(ch)) st_d.base[ch][DW-1:0] = wdata;
                if (idx == base_hi_idx(ch)) st_d.base[ch][AW-1:DW] = wdata[HW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= cfg_reset_value();
        else        st_q <= st_d;
    end

    assign cfg = st_q;
endmodule

// File: rtl/hio_chan_match.sv
`timescale 1ns/1ps
module hio_chan_match #(
    parameter int AW       = 16,
    parameter int PAIR_BIT = 2
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic          en,
    input  logic          strobe,
    output logic          hit,
    output logic          odd
);
    localparam logic [AW-1:0] CMP_MASK = ~(AW'(1) << PAIR_BIT);

    logic addr_eq;
    assign addr_eq = (((addr ^ base) & CMP_MASK) == '0);
    assign hit     = en & strobe & addr_eq;
    assign odd     = addr[PAIR_BIT];
endmodule

// File: rtl/hio_irq_route.sv
`timescale 1ns/1ps
module hio_irq_route
    import hio_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  irq_vec_t       req,
    input  logic [NCH-1:0] en,
    output irq_vec_t       irq
);
    irq_vec_t irq_d, irq_q;

    always_comb begin
        irq_d.kbd   = req.kbd   & en[CH_KBD];
        irq_d.mouse = req.mouse & en[CH_KBD];
        irq_d.pm    = req.pm    & en[CH_PM];
        irq_d.rtc   = req.rtc   & en[CH_RTC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/hostio_decode.sv
`timescale 1ns/1ps
module hostio_decode
    import hio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          kbd_req,
    input  logic          mouse_req,
    input  logic          pm_req,
    input  logic          rtc_req,
    output logic          kbd_dat_sel,
    output logic          kbd_cmd_sel,
    output logic          pm_dat_sel,
    output logic          pm_cmd_sel,
    output logic          rtc_idx_sel,
    output logic          rtc_dat_sel,
    output logic          irq1,
    output logic          irq12,
    output logic          irq11,
    output logic          irq8
);
    cfg_state_t            cfg_q;
    logic                  strobe;
    logic [NCH-1:0]        hit, odd, win;
    logic [NCH-1:0]        sel_even, sel_odd;
    irq_vec_t              req_v, irq_v;

    // signals observed by the bound checker
    logic                  cfg_lock;
    logic [NCH-1:0]        cfg_en;
    logic [NCH*AW-1:0]     cfg_bases;
    logic [5:0]            sel_all;
    logic [3:0]            irq_all;
    logic [3:0]            req_all;

    assign strobe = io_rd | io_wr;

    hio_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int PB = (c == CH_RTC) ? 0 : 2;
        hio_chan_match #(.AW(AW), .PAIR_BIT(PB)) u_match (
            .addr   (io_addr),
            .base   (cfg_q.base[c]),
            .en     (cfg_q.en[c]),
            .strobe (strobe),
            .hit    (hit[c]),
            .odd    (odd[c])
        );
    end

    // fixed priority: lower channel index wins an overlap
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            win[c] = hit[c] & ~taken;
            taken  = taken | hit[c];
        end
        sel_even = win & ~odd;
        sel_odd  = win & odd;
    end

    assign kbd_dat_sel = sel_even[CH_KBD];
    assign kbd_cmd_sel = sel_odd[CH_KBD];
    assign pm_dat_sel  = sel_even[CH_PM];
    assign pm_cmd_sel  = sel_odd[CH_PM];
    assign rtc_idx_sel = sel_even[CH_RTC];
    assign rtc_dat_sel = sel_odd[CH_RTC];

    assign req_v.kbd   = kbd_req;
    assign req_v.mouse = mouse_req;
    assign req_v.pm    = pm_req;
    assign req_v.rtc   = rtc_req;

    hio_irq_route u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_v),
        .en    (cfg_q.en),
        .irq   (irq_v)
    );

    assign irq1  = irq_v.kbd;
    assign irq12 = irq_v.mouse;
    assign irq11 = irq_v.pm;
    assign irq8  = irq_v.rtc;

    assign cfg_lock  = cfg_q.lock;
    assign cfg_en    = cfg_q.en;
    assign cfg_bases = cfg_q.base;
    assign sel_all   = {rtc_dat_sel, rtc_idx_sel, pm_cmd_sel, pm_dat_sel, kbd_cmd_sel, kbd_dat_sel};
    assign irq_all   = {irq1, irq12, irq11, irq8};
    assign req_all   = {kbd_req, mouse_req, pm_req, rtc_req};
endmodule

// File: rtl/hio_decode_chk.sv
`timescale 1ns/1ps
module hio_decode_chk
    import hio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic              cfg_lock,
    input logic [NCH-1:0]    cfg_en,
    input logic [NCH*AW-1:0] cfg_bases,
    input logic [5:0]        sel_all,
    input logic [3:0]        irq_all,
    input logic [3:0]        req_all
);
    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> cfg_lock);

    // R10
    locked_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> ($stable(cfg_en) && $stable(cfg_bases)));

    // R5
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_all));

    // R5
    idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> (sel_all == 6'b0));

    // R8
    disabled_kbd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en[CH_KBD] |-> (sel_all[1:0] == 2'b00));

    // R9
    kbd_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en[CH_KBD] |=> (irq_all[3:2] == 2'b00));

    // R9
    pm_irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_all[1] && cfg_en[CH_PM]) |=> irq_all[1]);
endmodule

bind hostio_decode hio_decode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .cfg_lock  (cfg_lock),
    .cfg_en    (cfg_en),
    .cfg_bases (cfg_bases),
    .sel_all   (sel_all),
    .irq_all   (irq_all),
    .req_all   (req_all)
);

// File: tb/sim_hostio_decode.sv
`timescale 1ns/1ps
module sim_hostio_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [3:0]  reqs = '0;   // {kbd, mouse, pm, rtc}
    logic kbd_dat_sel, kbd_cmd_sel, pm_dat_sel, pm_cmd_sel, rtc_idx_sel, rtc_dat_sel;
    logic irq1, irq12, irq11, irq8;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    hostio_decode u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .kbd_req(reqs[3]), .mouse_req(reqs[2]), .pm_req(reqs[1]), .rtc_req(reqs[0]),
        .kbd_dat_sel(kbd_dat_sel), .kbd_cmd_sel(kbd_cmd_sel),
        .pm_dat_sel(pm_dat_sel), .pm_cmd_sel(pm_cmd_sel),
        .rtc_idx_sel(rtc_idx_sel), .rtc_dat_sel(rtc_dat_sel),
        .irq1(irq1), .irq12(irq12), .irq11(irq11), .irq8(irq8)
    );

    wire [5:0] sel_vec = {rtc_dat_sel, rtc_idx_sel, pm_cmd_sel, pm_dat_sel, kbd_cmd_sel, kbd_dat_sel};
    wire [3:0] irq_vec = {irq1, irq12, irq11, irq8};

    // reference model of the configuration
    logic [15:0] m_base [3];
    logic [2:0]  m_en;
    bit          m_lock;

    function automatic void model_reset();
        m_base[0] = 16'h0060; m_base[1] = 16'h0062; m_base[2] = 16'h0070;
        m_en = 3'b111; m_lock = 1'b0;
    endfunction

    function automatic void model_write(input logic [2:0] idx, input logic [7:0] d);
        if (m_lock) return;
        case (idx)
            3'd0: begin m_en = d[2:0]; m_lock = d[7]; end
            3'd1: m_base[0][7:0]  = d;
            3'd2: m_base[0][15:8] = d;
            3'd3: m_base[1][7:0]  = d;
            3'd4: m_base[1][15:8] = d;
            3'd5: m_base[2][7:0]  = d;
            3'd6: m_base[2][15:8] = d;
            default: ;
        endcase
    endfunction

    function automatic logic [5:0] exp_sel(input logic [15:0] a, input logic st);
        logic hk, hp, hr;
        hk = st && m_en[0] && (((a ^ m_base[0]) & 16'hFFFB) == 16'h0);
        hp = st && m_en[1] && (((a ^ m_base[1]) & 16'hFFFB) == 16'h0) && !hk;
        hr = st && m_en[2] && (((a ^ m_base[2]) & 16'hFFFE) == 16'h0) && !hk && !hp;
        return {hr & a[0], hr & ~a[0], hp & a[2], hp & ~a[2], hk & a[2], hk & ~a[2]};
    endfunction

    function automatic logic [3:0] exp_irq(input logic [3:0] rq);
        return rq & {m_en[0], m_en[0], m_en[1], m_en[2]};
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: selects checked before the edge, IRQs after it
    task automatic step(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [3:0] rq, input logic we, input logic [2:0] idx,
                        input logic [7:0] d, input string tag_sel, input string tag_irq);
        logic [3:0] ei;
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr; reqs = rq;
        cfg_we = we; cfg_idx = idx; cfg_wdata = d;
        #1;
        chk({10'b0, sel_vec}, {10'b0, exp_sel(a, rd | wr)}, tag_sel);
        ei = exp_irq(rq);
        if (we) model_write(idx, d);
        @(posedge clk);
        #1;
        chk({12'b0, irq_vec}, {12'b0, ei}, tag_irq);
    endtask

    task automatic cfg_wr(input logic [2:0] idx, input logic [7:0] d, input string tag);
        step(16'h0000, 1'b0, 1'b0, 4'b0, 1'b1, idx, d, tag, tag);
    endtask

    task automatic probe(input logic [15:0] a, input string tag);
        step(a, 1'b1, 1'b0, 4'b0, 1'b0, 3'd0, 8'd0, tag, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; io_rd = 1'b0; io_wr = 1'b0; reqs = '0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h0005EED1));
        model_reset();
        do_reset();
        #1;
        // R1 reset state
        chk({12'b0, irq_vec}, 16'h0, "R1 irq after reset");
        chk({10'b0, sel_vec}, 16'h0, "R1 sel idle after reset");
        probe(16'h0060, "R1 R2 kbd data default");
        probe(16'h0064, "R2 kbd cmd");
        probe(16'h1060, "R2 upper bits compared");
        probe(16'h0061, "R2 bit0 not ignored");
        probe(16'h0062, "R3 pm data default");
        probe(16'h0066, "R3 pm cmd");
        probe(16'h0063, "R3 off-pair");
        probe(16'h0070, "R4 rtc index");
        probe(16'h0071, "R4 rtc data");
        probe(16'h0072, "R4 off-pair");
        step(16'h0060, 1'b0, 1'b0, 4'b0, 1'b0, 3'd0, 8'd0, "R5 no strobe", "R5");
        step(16'h0066, 1'b0, 1'b1, 4'b0, 1'b0, 3'd0, 8'd0, "R5 write strobe", "R5");
        step(16'h0000, 1'b0, 1'b0, 4'b1111, 1'b0, 3'd0, 8'd0, "R9", "R9 all irqs");
        step(16'h0000, 1'b0, 1'b0, 4'b0100, 1'b0, 3'd0, 8'd0, "R9", "R9 mouse to irq12");
        // R6 overlap: move pm onto the keyboard range
        cfg_wr(3'd3, 8'h60, "R7 pm base lo");
        probe(16'h0060, "R6 kbd beats pm");
        probe(16'h0062, "R7 pm moved away");
        cfg_wr(3'd0, 8'h06, "R8 disable kbd");
        probe(16'h0060, "R8 R6 falls to pm");
        step(16'h0000, 1'b0, 1'b0, 4'b1111, 1'b0, 3'd0, 8'd0, "R8", "R9 kbd irqs masked");
        cfg_wr(3'd5, 8'h60, "R7 rtc base lo");
        probe(16'h0060, "R6 pm beats rtc");
        probe(16'h0061, "R4 rtc data relocated");
        cfg_wr(3'd6, 8'h12, "R7 rtc base hi");
        probe(16'h1260, "R7 rtc high byte");
        cfg_wr(3'd7, 8'hFF, "R7 index 7");
        probe(16'h1261, "R7 index 7 no effect");
        probe(16'h0064, "R7 index 7 no effect pm");

        // random phase, configuration stays unlocked
        for (int i = 0; i < 2500; i++) begin
            logic [15:0] a;
            logic [2:0]  idx;
            logic [7:0]  d;
            logic        we;
            int          ch;
            ch = int'($urandom_range(2, 0));
            if ($urandom_range(9, 0) < 6) a = m_base[ch] ^ 16'($urandom_range(7, 0));
            else a = 16'($urandom);
            we  = ($urandom_range(9, 0) == 0);
            idx = 3'($urandom_range(7, 0));
            if (idx == 3'd0)      d = 8'($urandom_range(7, 0));
            else if (idx[0] == 1'b0 && $urandom_range(4, 0) != 0) d = 8'h00;
            else                  d = 8'($urandom);
            step(a, 1'($urandom), 1'($urandom), 4'($urandom), we, idx, d,
                 "R2 R3 R4 R5 R6 R8 random select", "R9 random irq");
        end

        // R10 lock behaviour from a fresh reset
        do_reset();
        cfg_wr(3'd1, 8'h80, "R7 kbd base lo");
        probe(16'h0080, "R7 kbd relocated");
        cfg_wr(3'd0, 8'h87, "R10 set lock");
        cfg_wr(3'd1, 8'h60, "R10 base write after lock");
        cfg_wr(3'd0, 8'h00, "R10 ctrl write after lock");
        cfg_wr(3'd0, 8'h07, "R10 lock clear attempt");
        probe(16'h0080, "R10 base kept");
        probe(16'h0060, "R10 old address stays dead");
        probe(16'h0062, "R10 pm still enabled");
        step(16'h0000, 1'b0, 1'b0, 4'b1111, 1'b0, 3'd0, 8'd0, "R10", "R10 enables kept");
        for (int i = 0; i < 200; i++) begin
            logic [15:0] a;
            a = m_base[$urandom_range(2, 0)] ^ 16'($urandom_range(7, 0));
            step(a, 1'b1, 1'b0, 4'($urandom), 1'b1, 3'($urandom_range(6, 0)), 8'($urandom),
                 "R10 locked random", "R10 locked irq");
        end
        do_reset();
        probe(16'h0060, "R1 R10 reset restores base");
        cfg_wr(3'd0, 8'h06, "R10 unlocked by reset");
        probe(16'h0060, "R10 write accepted after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule